// File: doc/BRIEF.md
# DMA Synchronization Event Conditioner

This block sits between the external synchronization request lines of one DMA channel and that channel's transfer sequencer. There are two directions, read (index 0) and write (index 1). Each direction has a raw event input, a flag that marks the event as coming from an external interrupt pin, and a polarity bit. The block resynchronizes each raw event into the local clock domain. It applies the polarity only to external-pin sources and turns the result into a pending status that the sequencer consumes and software can clear.

A shared frame-sync-ignore control selects the trigger mode. When it is low, a pending status is latched on each active edge. If a second active edge arrives while a status is still pending, the block raises a sticky drop flag. When the control is high, the pending status tracks the conditioned level, and it is masked while the sequencer reports a burst in progress. Transitions during a burst therefore have no effect in that mode.

Top module: `dsync_cond`

## Requirements
- R1: A change on a raw event input passes through a SYNC_STAGES-flop synchronizer. With the default of 2, its effect on `pend` is first visible after the third rising clock edge following the change.
- R2: `pol_low[d]`=1 makes the event active low, but only when `src_ext[d]`=1. When `src_ext[d]`=0, the event is always active high, whatever `pol_low[d]` holds.
- R3: With `lvl_mode`=0, `pend[d]` sets on an inactive-to-active transition of the conditioned event. A level that stays active does not set it again after it has been cleared.
- R4: A high `sw_clr[d]` clears both `pend[d]` and `drop[d]` on the next edge. It wins over a simultaneous edge, consume or level request.
- R5: With `lvl_mode`=0, a one-cycle `consume[d]` pulse clears `pend[d]` on the next edge.
- R6: With `lvl_mode`=0, an active edge while `pend[d]` is already set, with no consume or clear in that cycle, sets `drop[d]`. Once set, `drop[d]` stays set until `sw_clr[d]`.
- R7: With `lvl_mode`=1, `pend[d]` is the registered value of (conditioned event active AND NOT `burst_active`). Transitions during a burst are ignored, and `drop[d]` stays 0.
- R8: The two directions are independent. Index 0 is read and index 1 is write. Stimulus on one direction never changes the other direction's outputs.
- R9: After reset, `pend` and `drop` are 0, and the conditioned events are masked until the synchronizer has filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_raw | input | 2 | Raw sync events, [0] read, [1] write |
| src_ext | input | 2 | 1 = event comes from an external interrupt pin |
| pol_low | input | 2 | Polarity per direction, 1 = active low (external pin only) |
| lvl_mode | input | 1 | Frame-sync-ignore: 1 = level triggered with burst masking, 0 = edge triggered |
| burst_active | input | 1 | Sequencer has a burst in progress |
| consume | input | 2 | Sequencer took the pending event (one-cycle pulse) |
| sw_clr | input | 2 | Software clear of status and drop flag |
| pend | output | 2 | Pending sync status per direction |
| drop | output | 2 | Sticky lost-event flag per direction |

## Verification
The bench builds the block with SYNC_STAGES=2 and DROP_EN=1. This keeps the event-to-status latency at exactly three edges, so every expected value lands on a known cycle. With only two directions, two source settings, two polarities and two modes, the bench sweeps all sixteen combinations. In each one it runs the edge sequence (set, consume, no retrigger, drop, clear racing an edge) or the level sequence (burst masking, level following, clear priority), and checks that the idle direction stays quiet.

// File: rtl/dsync_pkg.sv
package dsync_pkg;
   localparam int unsigned DIR_N  = 2;
   localparam int unsigned DIR_RD = 0;
   localparam int unsigned DIR_WR = 1;

   typedef enum logic {
      TRIG_EDGE  = 1'b0,
      TRIG_LEVEL = 1'b1
   } trig_mode_e;
endpackage

// File: rtl/dsync_sync.sv
module dsync_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q,
   output logic valid
);
   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("dsync_sync: STAGES must be at least 2");
   end

   logic [LAST:0] chain;
   logic [LAST:0] fill;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain[0] <= 1'b0;
         fill[0]  <= 1'b0;
      end else begin
         chain[0] <= d;
         fill[0]  <= 1'b1;
      end
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[i] <= 1'b0;
            fill[i]  <= 1'b0;
         end else begin
            chain[i] <= chain[i-1];
            fill[i]  <= fill[i-1];
         end
      end
   end

   assign q     = chain[LAST];
   assign valid = fill[LAST];

   // R9: once the chain has filled it stays valid until reset
   a_r9_valid_holds: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> valid);
endmodule

// File: rtl/dsync_lane.sv
module dsync_lane #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          DROP_EN     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   input  logic src_ext,
   input  logic pol_low,
   input  logic lvl_mode,
   input  logic burst_active,
   input  logic consume,
   input  logic sw_clr,
   output logic pend,
   output logic drop
);
   import dsync_pkg::*;

   logic s_evt;
   logic s_vld;
   logic cond;
   logic cond_q;
   logic edge_hit;
   logic level_req;
   trig_mode_e mode;

   dsync_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw),
      .q     (s_evt),
      .valid (s_vld)
   );

   assign mode      = trig_mode_e'(lvl_mode);
   assign cond      = s_vld & (src_ext ? (s_evt ^ pol_low) : s_evt);
   assign edge_hit  = cond & ~cond_q;
   assign level_req = cond & ~burst_active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cond_q <= 1'b0;
      else        cond_q <= cond;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 pend <= 1'b0;
      else if (sw_clr)            pend <= 1'b0;
      else if (mode == TRIG_LEVEL) pend <= level_req;
      else if (edge_hit)          pend <= 1'b1;
      else if (consume)           pend <= 1'b0;
   end

   if (DROP_EN) begin : g_drop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      drop <= 1'b0;
         else if (sw_clr) drop <= 1'b0;
         else if (mode == TRIG_EDGE && edge_hit && pend && !consume)
            drop <= 1'b1;
      end

      // R6: lost-event flag is sticky until software clears it
      a_r6_drop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         drop && !sw_clr |=> drop);
   end else begin : g_nodrop
      assign drop = 1'b0;
   end

   // R3: an active edge in edge mode leaves the status set
   a_r3_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
      !lvl_mode && edge_hit && !sw_clr |=> pend);

   // R4: software clear overrides every set source
   a_r4_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
      sw_clr |=> !pend && !drop);

   // R5: consume without a coincident edge empties the status
   a_r5_consume_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !lvl_mode && consume && !edge_hit && !sw_clr |=> !pend);

   // R7: a burst masks the level request
   a_r7_burst_masks: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_mode && burst_active |=> !pend);
endmodule

// File: rtl/dsync_cond.sv
module dsync_cond #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          DROP_EN     = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] evt_raw,
   input  logic [1:0] src_ext,
   input  logic [1:0] pol_low,
   input  logic       lvl_mode,
   input  logic       burst_active,
   input  logic [1:0] consume,
   input  logic [1:0] sw_clr,
   output logic [1:0] pend,
   output logic [1:0] drop
);
   import dsync_pkg::*;

   if (DIR_N != 2) begin : g_bad_dirs
      $error("dsync_cond: port widths assume two directions");
   end

   for (genvar d = 0; d < DIR_N; d++) begin : g_dir
      dsync_lane #(
         .SYNC_STAGES (SYNC_STAGES),
         .DROP_EN     (DROP_EN)
      ) u_lane (
         .clk          (clk),
         .rst_n        (rst_n),
         .raw          (evt_raw[d]),
         .src_ext      (src_ext[d]),
         .pol_low      (pol_low[d]),
         .lvl_mode     (lvl_mode),
         .burst_active (burst_active),
         .consume      (consume[d]),
         .sw_clr       (sw_clr[d]),
         .pend         (pend[d]),
         .drop         (drop[d])
      );
   end

   // R8: a clear on one direction never disturbs the other
   a_r8_lanes_apart: assert property (@(posedge clk) disable iff (!rst_n)
      sw_clr[DIR_RD] && !sw_clr[DIR_WR] && drop[DIR_WR] |=> drop[DIR_WR]);
endmodule

// File: tb/sim_dsync_cond.sv
module sim_dsync_cond;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] evt_raw = '0, src_ext = '0, pol_low = '0, consume = '0, sw_clr = '0;
   logic       lvl_mode = 1'b0, burst_active = 1'b0;
   logic [1:0] pend, drop;
   int checks = 0, errors = 0;

   always #2 clk = ~clk;

   dsync_cond #(.SYNC_STAGES(2), .DROP_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .evt_raw(evt_raw), .src_ext(src_ext),
      .pol_low(pol_low), .lvl_mode(lvl_mode), .burst_active(burst_active),
      .consume(consume), .sw_clr(sw_clr), .pend(pend), .drop(drop));

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      for (int combo = 0; combo < 16; combo++) begin
         int  d   = combo & 1;
         int  o   = 1 - d;
         bit  src = combo[1];
         bit  pol = combo[2];
         bit  lvl = combo[3];
         bit  act = !(src && pol);  // R2 active value
         rst_n = 1'b0;
         src_ext = {src, src}; pol_low = {pol, pol}; lvl_mode = lvl;
         evt_raw = {!act, !act}; consume = '0; sw_clr = '0; burst_active = 1'b0;
         cyc(2);
         rst_n = 1'b1;
         cyc(4);
         chk("R9 pend idle", pend[d], 1'b0);
         chk("R9 drop idle", drop[d], 1'b0);
         evt_raw[d] = act;
         cyc(2);
         chk("R1 not yet", pend[d], 1'b0);
         cyc(1);
         chk("R1/R2 pend after sync", pend[d], 1'b1);
         chk("R8 other quiet", pend[o], 1'b0);
         if (!lvl) begin
            consume[d] = 1'b1; cyc(1); consume[d] = 1'b0;
            chk("R5 consume clears", pend[d], 1'b0);
            cyc(3);
            chk("R3 no retrigger", pend[d], 1'b0);
            evt_raw[d] = !act; cyc(3);
            evt_raw[d] = act;  cyc(3);
            chk("R3 new edge", pend[d], 1'b1);
            evt_raw[d] = !act; cyc(3);
            evt_raw[d] = act;  cyc(3);
            chk("R6 drop set", drop[d], 1'b1);
            chk("R6 pend kept", pend[d], 1'b1);
            chk("R8 other drop", drop[o], 1'b0);
            cyc(2);
            chk("R6 drop sticky", drop[d], 1'b1);
            sw_clr[d] = 1'b1; cyc(1); sw_clr[d] = 1'b0;
            chk("R4 clr pend", pend[d], 1'b0);
            chk("R4 clr drop", drop[d], 1'b0);
            evt_raw[d] = !act; cyc(3);
            evt_raw[d] = act;  cyc(2);
            sw_clr[d] = 1'b1; cyc(1); sw_clr[d] = 1'b0;
            chk("R4 clr beats edge", pend[d], 1'b0);
         end else begin
            burst_active = 1'b1; cyc(1);
            chk("R7 burst masks", pend[d], 1'b0);
            evt_raw[d] = !act; cyc(3);
            evt_raw[d] = act;  cyc(3);
            chk("R7 toggles ignored", pend[d], 1'b0);
            burst_active = 1'b0; cyc(1);
            chk("R7 level follows", pend[d], 1'b1);
            evt_raw[d] = !act; cyc(3);
            chk("R7 level drops", pend[d], 1'b0);
            chk("R7 no drop", drop[d], 1'b0);
            evt_raw[d] = act; cyc(3);
            sw_clr[d] = 1'b1; cyc(1);
            chk("R4 clr beats level", pend[d], 1'b0);
            sw_clr[d] = 1'b0; cyc(1);
            chk("R7 level returns", pend[d], 1'b1);
         end
         chk("R8 other pend end", pend[o], 1'b0);
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule